// File: doc/BRIEF.md
# PCI-to-ISA Bridge Configuration Space

This block holds the configuration registers of a two-function PCI-to-ISA bridge. A byte-wide port carries a function number, an 8-bit register offset, write data and a write strobe. Reads are combinational and return the stored byte of the addressed function and offset. Function 0 carries the identification bytes, a set of control bytes with per-offset write masks, and two bytes of packed interrupt routing. Function 1 carries the enable bit for the internal IDE channels.

The routing bytes drive four live 4-bit outputs, one for each PCI interrupt line A to D. Each output gives the ISA IRQ number, and a zero nibble means the line is disabled. A build parameter selects the variant with internal IDE. Only that variant drives the IDE enable output. A second parameter sets the device ID. The surrounding configuration-cycle decoder and the IDE controller are connected to these ports.

Top module: `pisa_cfg_space`

## Requirements
- R1: After reset, function 0 reads 0x60, 0x10, DEV_ID[7:0], DEV_ID[15:8] at offsets 0 to 3, 0x01 at offset 8, 0x00 at offset 9, 0x01 at offset 0x0A, 0x06 at offset 0x0B, and 0x00 at every other offset that has not been written.
- R2: Writes to offsets 0 to 3 of either function leave the stored bytes unchanged.
- R3: Function 0 offset 0x43 routes INTA from bits 3:0 and INTB from bits 7:4. Offset 0x44 routes INTC from bits 3:0 and INTD from bits 7:4. The route outputs take the new value on the clock edge that performs the write.
- R4: `irq_route_en[n]` is 1 exactly when the route nibble of line n (0=A, 1=B, 2=C, 3=D) is nonzero. A zero nibble marks the line as disabled.
- R5: After reset all four route outputs are 0 and `irq_route_en` is 4'b0000.
- R6: A function 0 write stores data AND mask, and the bits outside the mask read as 0. The masks are 0xAF at 0x46, 0x4F at 0x47, 0x38 at 0x57, 0x01 at 0x71, 0x02 at 0x90, 0x1F at 0x92, 0xFC at 0xA0 and 0x88 at 0xA4.
- R7: Every other offset above 3 in function 0 or function 1 stores and reads back the full written byte.
- R8: With IDE_ON=1, bit 0 of function 1 offset 4 drives `ide_enable`. After reset that byte is 0x01 and `ide_enable` is 1.
- R9: With IDE_ON=0, `ide_enable` is 0 whatever is written, and function 1 offset 4 resets to 0x00.
- R10: `smi_alt_irq` is 15 when bit 7 of function 0 offset 0x46 is 1, and 10 when that bit is 0.
- R11: Function numbers other than 0 and 1 read 0x00, and writes to them change no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_func | input | FUNC_W | Function number of the access |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe, one write per cycle |
| cfg_rdata | output | 8 | Read data for cfg_func/cfg_addr |
| irq_route_a | output | 4 | ISA IRQ for INTA |
| irq_route_b | output | 4 | ISA IRQ for INTB |
| irq_route_c | output | 4 | ISA IRQ for INTC |
| irq_route_d | output | 4 | ISA IRQ for INTD |
| irq_route_en | output | 4 | Per-line route active flag (bit 0 = A) |
| smi_alt_irq | output | 4 | IRQ used in place of an SMI request |
| ide_enable | output | 1 | Internal IDE channels enabled |

## Verification
The bench builds two instances side by side from the same stimulus. The default instance has IDE_ON=1 and DEV_ID=0x886A. The second has IDE_ON=0 and DEV_ID=0x8886. Together they show that the identification bytes follow the parameter, that the IDE bit resets to 1 only in the IDE variant, and that `ide_enable` stays low in the other variant even after a write of 1. Both instances are also driven through the masked offsets, the routing nibbles including zero, and accesses to function 2.

// File: rtl/pisa_cfg_pkg.sv
package pisa_cfg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << ADDR_W;

    typedef enum logic [1:0] {
        FN_BRIDGE = 2'd0,
        FN_IDE    = 2'd1
    } cfg_fn_e;

    localparam logic [ADDR_W-1:0] OFF_ROUTE_AB = 8'h43;
    localparam logic [ADDR_W-1:0] OFF_ROUTE_CD = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_SMI_CTL  = 8'h46;
    localparam logic [ADDR_W-1:0] OFF_IDE_CTL  = 8'h04;

    typedef struct packed {
        logic [3:0] d;
        logic [3:0] c;
        logic [3:0] b;
        logic [3:0] a;
    } irq_map_t;

    // Bits that a write may set; offsets 0..3 are never writable.
    function automatic logic [DATA_W-1:0] wmask(input cfg_fn_e fn, input int off);
        logic [DATA_W-1:0] m;
        if (off < 4) begin
            m = '0;
        end else if (fn == FN_IDE) begin
            m = '1;
        end else begin
            case (off)
                8'h46:   m = 8'hAF;
                8'h47:   m = 8'h4F;
                8'h57:   m = 8'h38;
                8'h71:   m = 8'h01;
                8'h90:   m = 8'h02;
                8'h92:   m = 8'h1F;
                8'hA0:   m = 8'hFC;
                8'hA4:   m = 8'h88;
                default: m = '1;
            endcase
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] rst_val(input cfg_fn_e fn, input int off,
                                                  input logic [15:0] dev_id, input logic ide_on);
        logic [DATA_W-1:0] v;
        v = '0;
        if (fn == FN_BRIDGE) begin
            case (off)
                0:  v = 8'h60;
                1:  v = 8'h10;
                2:  v = dev_id[7:0];
                3:  v = dev_id[15:8];
                8:  v = 8'h01;
                10: v = 8'h01;
                11: v = 8'h06;
                default: v = '0;
            endcase
        end else if (off == 4) begin
            v = {7'b0, ide_on};
        end
        return v;
    endfunction

    function automatic logic [3:0] smi_irq(input logic sel15);
        return sel15 ? 4'd15 : 4'd10;
    endfunction

endpackage

// File: rtl/pisa_cfg_bank.sv
module pisa_cfg_bank
    import pisa_cfg_pkg::*;
#(
    parameter cfg_fn_e     FN     = FN_BRIDGE,
    parameter logic [15:0] DEV_ID = 16'h886A,
    parameter bit          IDE_ON = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] regs [NREG]
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RV = rst_val(FN, i, DEV_ID, IDE_ON);
        localparam logic [DATA_W-1:0] WM = wmask(FN, i);
        if (i < 4) begin : g_ro
            always_ff @(posedge clk) begin
                if (rst) regs[i] <= RV;
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= RV;
                else if (wr_en && addr == ADDR_W'(i))
                    regs[i] <= wdata & WM;
            end
        end
    end

    p_id_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr < 4) |=> regs[$past(addr)] == $past(regs[addr]));

    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr > 3) |=>
        ((regs[$past(addr)] & ~wmask(FN, int'($past(addr)))) == '0));

endmodule

// File: rtl/pisa_irq_route.sv
module pisa_irq_route
    import pisa_cfg_pkg::*;
#(
    parameter bit IDE_ON = 1'b1
) (
    input  logic [DATA_W-1:0] route_ab,
    input  logic [DATA_W-1:0] route_cd,
    input  logic [DATA_W-1:0] smi_ctl,
    input  logic [DATA_W-1:0] ide_ctl,
    output irq_map_t          map,
    output logic [3:0]        map_en,
    output logic [3:0]        smi_line,
    output logic              ide_on_o
);

    always_comb begin
        map.a = route_ab[3:0];
        map.b = route_ab[7:4];
        map.c = route_cd[3:0];
        map.d = route_cd[7:4];
    end

    assign map_en[0] = |map.a;
    assign map_en[1] = |map.b;
    assign map_en[2] = |map.c;
    assign map_en[3] = |map.d;

    assign smi_line = smi_irq(smi_ctl[7]);

    if (IDE_ON) begin : g_ide
        assign ide_on_o = ide_ctl[0];
    end else begin : g_no_ide
        assign ide_on_o = 1'b0;
    end

endmodule

// File: rtl/pisa_cfg_space.sv
module pisa_cfg_space
    import pisa_cfg_pkg::*;
#(
    parameter int          FUNC_W = 3,
    parameter logic [15:0] DEV_ID = 16'h886A,
    parameter bit          IDE_ON = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [7:0]        cfg_rdata,
    output logic [3:0]        irq_route_a,
    output logic [3:0]        irq_route_b,
    output logic [3:0]        irq_route_c,
    output logic [3:0]        irq_route_d,
    output logic [3:0]        irq_route_en,
    output logic [3:0]        smi_alt_irq,
    output logic              ide_enable
);

    logic [DATA_W-1:0] f0_regs [NREG];
    logic [DATA_W-1:0] f1_regs [NREG];
    logic              sel_f0, sel_f1;
    irq_map_t          map;

    assign sel_f0 = (cfg_func == FUNC_W'(FN_BRIDGE));
    assign sel_f1 = (cfg_func == FUNC_W'(FN_IDE));

    pisa_cfg_bank #(.FN(FN_BRIDGE), .DEV_ID(DEV_ID), .IDE_ON(IDE_ON)) u_fn0 (
        .clk(clk), .rst(rst), .wr_en(cfg_we && sel_f0),
        .addr(cfg_addr), .wdata(cfg_wdata), .regs(f0_regs)
    );

    pisa_cfg_bank #(.FN(FN_IDE), .DEV_ID(DEV_ID), .IDE_ON(IDE_ON)) u_fn1 (
        .clk(clk), .rst(rst), .wr_en(cfg_we && sel_f1),
        .addr(cfg_addr), .wdata(cfg_wdata), .regs(f1_regs)
    );

    always_comb begin
        if (sel_f0)      cfg_rdata = f0_regs[cfg_addr];
        else if (sel_f1) cfg_rdata = f1_regs[cfg_addr];
        else             cfg_rdata = '0;
    end

    pisa_irq_route #(.IDE_ON(IDE_ON)) u_route (
        .route_ab(f0_regs[OFF_ROUTE_AB]),
        .route_cd(f0_regs[OFF_ROUTE_CD]),
        .smi_ctl (f0_regs[OFF_SMI_CTL]),
        .ide_ctl (f1_regs[OFF_IDE_CTL]),
        .map     (map),
        .map_en  (irq_route_en),
        .smi_line(smi_alt_irq),
        .ide_on_o(ide_enable)
    );

    assign irq_route_a = map.a;
    assign irq_route_b = map.b;
    assign irq_route_c = map.c;
    assign irq_route_d = map.d;

    p_route_ab_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && sel_f0 && cfg_addr == OFF_ROUTE_AB) |=>
        (irq_route_a == $past(cfg_wdata[3:0]) && irq_route_b == $past(cfg_wdata[7:4])));

    p_route_cd_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && sel_f0 && cfg_addr == OFF_ROUTE_CD) |=>
        (irq_route_c == $past(cfg_wdata[3:0]) && irq_route_d == $past(cfg_wdata[7:4])));

    p_smi_pair_r10: assert property (@(posedge clk) disable iff (rst)
        (smi_alt_irq == 4'd15 || smi_alt_irq == 4'd10));

    if (!IDE_ON) begin : g_chk_no_ide
        p_ide_off_r9: assert property (@(posedge clk) disable iff (rst) !ide_enable);
    end

endmodule

// File: tb/tb_pisa_cfg_space.sv
module tb_pisa_cfg_space;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_func = '0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cfg_we = 1'b0;

    logic [7:0] rd_a, rd_f;
    logic [3:0] ra_a, rb_a, rc_a, rd_a4, en_a, smi_a;
    logic [3:0] ra_f, rb_f, rc_f, rd_f4, en_f, smi_f;
    logic       ide_a, ide_f;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pisa_cfg_space #(.FUNC_W(3), .DEV_ID(16'h886A), .IDE_ON(1'b1)) dut (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(rd_a),
        .irq_route_a(ra_a), .irq_route_b(rb_a), .irq_route_c(rc_a), .irq_route_d(rd_a4),
        .irq_route_en(en_a), .smi_alt_irq(smi_a), .ide_enable(ide_a)
    );

    pisa_cfg_space #(.FUNC_W(3), .DEV_ID(16'h8886), .IDE_ON(1'b0)) dut_f (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(rd_f),
        .irq_route_a(ra_f), .irq_route_b(rb_f), .irq_route_c(rc_f), .irq_route_d(rd_f4),
        .irq_route_en(en_f), .smi_alt_irq(smi_f), .ide_enable(ide_f)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int fn, input int a, input int d);
        @(negedge clk);
        cfg_func = 3'(fn); cfg_addr = 8'(a); cfg_wdata = 8'(d); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int fn, input int a);
        @(negedge clk);
        cfg_func = 3'(fn); cfg_addr = 8'(a); cfg_we = 1'b0;
        #2;
    endtask

    task automatic t_reset_r1;
        rd(0, 0); chk("R1 vid lo", rd_a, 8'h60);
        rd(0, 1); chk("R1 vid hi", rd_a, 8'h10);
        rd(0, 2); chk("R1 did lo", rd_a, 8'h6A); chk("R1 did lo F", rd_f, 8'h86);
        rd(0, 3); chk("R1 did hi", rd_a, 8'h88); chk("R1 did hi F", rd_f, 8'h88);
        rd(0, 8); chk("R1 rev", rd_a, 8'h01);
        rd(0, 9); chk("R1 progif", rd_a, 8'h00);
        rd(0, 10); chk("R1 subclass", rd_a, 8'h01);
        rd(0, 11); chk("R1 class", rd_a, 8'h06);
        rd(0, 8'h60); chk("R1 other", rd_a, 8'h00);
    endtask

    task automatic t_reset_r5;
        chk("R5 routes A", {ra_a, rb_a, rc_a, rd_a4}, 0);
        chk("R5 en A", en_a, 0);
        chk("R5 en F", en_f, 0);
        chk("R10 reset smi", smi_a, 10);
    endtask

    task automatic t_ide_r8_r9;
        chk("R8 ide reset", ide_a, 1);
        rd(1, 4); chk("R8 ide byte", rd_a, 8'h01);
        chk("R9 ide reset F", ide_f, 0);
        chk("R9 ide byte F", rd_f, 8'h00);
        wr(1, 4, 8'h00);
        chk("R8 ide off", ide_a, 0);
        wr(1, 4, 8'h01);
        chk("R8 ide on", ide_a, 1);
        chk("R9 ide stays 0", ide_f, 0);
    endtask

    task automatic t_ro_r2;
        wr(0, 0, 8'hFF); wr(0, 2, 8'h00); wr(1, 3, 8'h5A);
        rd(0, 0); chk("R2 fn0 off0", rd_a, 8'h60);
        rd(0, 2); chk("R2 fn0 off2", rd_a, 8'h6A);
        rd(1, 3); chk("R2 fn1 off3", rd_a, 8'h00);
    endtask

    task automatic t_route_r3_r4;
        wr(0, 8'h43, 8'hB5);
        chk("R3 INTA", ra_a, 5); chk("R3 INTB", rb_a, 11);
        chk("R4 en ab", en_a, 4'b0011);
        wr(0, 8'h44, 8'h09);
        chk("R3 INTC", rc_a, 9); chk("R3 INTD", rd_a4, 0);
        chk("R4 en d off", en_a, 4'b0111);
        wr(0, 8'h44, 8'hE0);
        chk("R3 INTD2", rd_a4, 14); chk("R4 en c off", en_a, 4'b1011);
        wr(0, 8'h43, 8'h00);
        chk("R4 all ab off", en_a, 4'b1000);
        chk("R3 F INTD", rd_f4, 14);
    endtask

    task automatic t_mask_r6;
        int offs [8] = '{8'h46, 8'h47, 8'h57, 8'h71, 8'h90, 8'h92, 8'hA0, 8'hA4};
        int msk  [8] = '{8'hAF, 8'h4F, 8'h38, 8'h01, 8'h02, 8'h1F, 8'hFC, 8'h88};
        for (int i = 0; i < 8; i++) begin
            wr(0, offs[i], 8'hFF);
            rd(0, offs[i]);
            chk($sformatf("R6 mask off 0x%0h", offs[i]), rd_a, msk[i]);
        end
    endtask

    task automatic t_smi_r10;
        wr(0, 8'h46, 8'h80); chk("R10 sel 15", smi_a, 15);
        wr(0, 8'h46, 8'h7F); chk("R10 sel 10", smi_a, 10);
        rd(0, 8'h46); chk("R6 46 low", rd_a, 8'h2F);
    endtask

    task automatic t_full_r7;
        wr(0, 8'h50, 8'hA5); rd(0, 8'h50); chk("R7 fn0 full", rd_a, 8'hA5);
        wr(0, 8'hFF, 8'h3C); rd(0, 8'hFF); chk("R7 fn0 top", rd_a, 8'h3C);
        wr(1, 8'h40, 8'hC3); rd(1, 8'h40); chk("R7 fn1 full", rd_a, 8'hC3);
        chk("R7 fn1 full F", rd_f, 8'hC3);
    endtask

    task automatic t_badfn_r11;
        wr(2, 8'h50, 8'h11); wr(3, 8'h43, 8'h77);
        rd(2, 0); chk("R11 fn2 read", rd_a, 0);
        rd(0, 8'h50); chk("R11 fn0 untouched", rd_a, 8'hA5);
        chk("R11 routes untouched", rb_a, 0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_reset_r5();
        t_ide_r8_r9();
        t_ro_r2();
        t_route_r3_r4();
        t_mask_r6();
        t_smi_r10();
        t_full_r7();
        t_badfn_r11();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule